// File: doc/BRIEF.md
# Ones-Complement Adder and Bus Datapath

This block is the arithmetic slice of a 16-bit word machine. It holds two operand registers (X and Y), a carry-in flop and a buffer register B. A combinational ones-complement adder forms the sum U from X and Y. When the raw sum overflows the word, that carry is fed back into the lowest bit, which is the end-around carry. Setting the carry-in flop also adds one.

Control pulses gate U, B or the complement of B onto a read bus. When several pulses are active together, their sources merge by bitwise OR. Driving U together with the complement of B gives the masking operation. A second combinational stage forms the write bus from the read bus, ORed with any of eight selectable constants. Write pulses then load X, Y or B from the write bus, or set the carry-in flop. Every register updates on the rising clock edge.

Top module: `oc_bus_datapath`

## Requirements
- R1: While `rst_n` is low, X, Y, B and the carry-in flop are all zero.
- R2: `sum_u` equals the low 16 bits of X + Y + c. Here c is 1 when the 17-bit raw X+Y has bit 16 set or when the carry-in flop is 1, and 0 otherwise. For example, 0177777 + 0000001 gives 0000001.
- R3: `wr_x` loads X from the write bus, and `wr_b` loads B from the write bus, at the next rising edge.
- R4: `wr_y` loads Y from the write bus and clears X (a `wr_x` in the same cycle wins over the clear). It also clears the carry-in flop, unless `set_ci` is high in the same cycle.
- R5: `wr_y_only` loads Y from the write bus and leaves X and the carry-in flop unchanged.
- R6: `set_ci` sets the carry-in flop to 1.
- R7: `rd_u` drives U, `rd_b` drives B and `rd_bn` drives the bitwise inverse of B onto `rd_bus`. Active sources combine by bitwise OR, and with no read pulse `rd_bus` is zero.
- R8: `wr_bus` equals `rd_bus` ORed with each constant whose `k_sel` bit is high. The bits map as follows: bit0=020000, bit1=000001, bit2=177776, bit3=000002, bit4=100000, bit5=000022, bit6=000024, bit7=002000 (octal).
- R9: A register whose write pulse is low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rd_u | input | 1 | Gate sum U onto read bus |
| rd_b | input | 1 | Gate B onto read bus |
| rd_bn | input | 1 | Gate inverted B onto read bus |
| k_sel | input | 8 | Constant injection pulses (mapping in R8) |
| wr_x | input | 1 | Load X from write bus |
| wr_y | input | 1 | Load Y, clear X and carry-in |
| wr_y_only | input | 1 | Load Y only |
| wr_b | input | 1 | Load B from write bus |
| set_ci | input | 1 | Set carry-in flop |
| x_q | output | 16 | X register |
| y_q | output | 16 | Y register |
| b_q | output | 16 | B register |
| ci_q | output | 1 | Carry-in flop |
| sum_u | output | 16 | Ones-complement sum |
| rd_bus | output | 16 | Read bus |
| wr_bus | output | 16 | Write bus |

## Verification
On every cycle, the assertions check the following:
- the write bus always covers the read bus;
- an idle read bus is zero;
- the sum passes X through when Y and the carry-in are zero;
- the load, clear and set effects of the write pulses on X and the carry-in flop, one edge later.

Only the bench's scenarios can show the full end-around sum and the exact constant values. The same holds for the masking result of combined reads and for multi-step sequences such as negative zero plus one. The bench compares these against a behavioural model every cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int NUM_K = 8;
  typedef enum int {
    K_BIT13 = 0,
    K_ONE   = 1,
    K_NOT1  = 2,
    K_TWO   = 3,
    K_SIGN  = 4,
    K_O22   = 5,
    K_O24   = 6,
    K_BIT10 = 7
  } k_idx_e;
endpackage

// File: rtl/oc_adder.sv
module oc_adder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] u
);
  logic [W:0] raw;
  logic       eac;

  always_comb begin
    raw = {1'b0, x} + {1'b0, y};
    eac = raw[W] | ci;
    u   = raw[W-1:0] + {{(W-1){1'b0}}, eac};
  end

  // adding zero with no carry-in returns the operand unchanged
  assert_sum_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (y == '0 && !ci) |-> (u == x));
endmodule

// File: rtl/oc_read_bus.sv
module oc_read_bus #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_u,
  input  logic         rd_b,
  input  logic         rd_bn,
  input  logic [W-1:0] u,
  input  logic [W-1:0] b,
  output logic [W-1:0] bus
);
  logic [2:0][W-1:0] src;

  always_comb begin
    src[0] = rd_u  ? u  : '0;
    src[1] = rd_b  ? b  : '0;
    src[2] = rd_bn ? ~b : '0;
    bus = '0;
    for (int i = 0; i < 3; i++) bus = bus | src[i];
  end

  assert_idle_bus_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_u && !rd_b && !rd_bn) |-> (bus == '0));
endmodule

// File: rtl/oc_const_inject.sv
module oc_const_inject #(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             rd_bus,
  input  logic [oc_pkg::NUM_K-1:0] k_sel,
  output logic [W-1:0]             wr_bus
);
  import oc_pkg::*;

  function automatic logic [W-1:0] kval(input int idx);
    logic [W-1:0] v;
    v = '0;
    case (idx)
      K_BIT13: v[W-3] = 1'b1;
      K_ONE:   v[0] = 1'b1;
      K_NOT1:  v = ~{{(W-1){1'b0}}, 1'b1};
      K_TWO:   v[1] = 1'b1;
      K_SIGN:  v[W-1] = 1'b1;
      K_O22:   begin v[4] = 1'b1; v[1] = 1'b1; end
      K_O24:   begin v[4] = 1'b1; v[2] = 1'b1; end
      K_BIT10: v[W-6] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  logic [NUM_K-1:0][W-1:0] kterm;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_K; gi++) begin : g_k
      assign kterm[gi] = k_sel[gi] ? kval(gi) : '0;
    end
  endgenerate

  always_comb begin
    wr_bus = rd_bus;
    for (int i = 0; i < NUM_K; i++) wr_bus = wr_bus | kterm[i];
  end

  assert_wr_covers_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_bus & rd_bus) == rd_bus));
  assert_no_const_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (k_sel == '0) |-> (wr_bus == rd_bus));
endmodule

// File: rtl/oc_regs.sv
module oc_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wbus,
  input  logic         wr_x,
  input  logic         wr_y,
  input  logic         wr_y_only,
  input  logic         wr_b,
  input  logic         set_ci,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic [W-1:0] b_q,
  output logic         ci_q
);
  logic [W-1:0] x_d, y_d, b_d;
  logic         ci_d;
  logic         x_en, y_en, b_en, ci_en;

  always_comb begin
    x_en  = wr_x | wr_y;
    y_en  = wr_y | wr_y_only;
    b_en  = wr_b;
    ci_en = set_ci | wr_y;
    x_d   = wr_x ? wbus : '0;
    y_d   = wbus;
    b_d   = wbus;
    ci_d  = set_ci;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      b_q  <= '0;
      ci_q <= 1'b0;
    end else begin
      if (x_en)  x_q  <= x_d;
      if (y_en)  y_q  <= y_d;
      if (b_en)  b_q  <= b_d;
      if (ci_en) ci_q <= ci_d;
    end
  end

  assert_wry_clears_x_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_y && !wr_x) |=> (x_q == '0));
  assert_wry_clears_ci_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_y && !set_ci) |=> !ci_q);
  assert_setci_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_ci |=> ci_q);
  assert_wyonly_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_y_only && !wr_y && !wr_x && !set_ci) |=> ($stable(x_q) && $stable(ci_q)));
  assert_wrx_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_x |=> (x_q == $past(wbus)));
endmodule

// File: rtl/oc_bus_datapath.sv
module oc_bus_datapath #(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_u,
  input  logic                     rd_b,
  input  logic                     rd_bn,
  input  logic [oc_pkg::NUM_K-1:0] k_sel,
  input  logic                     wr_x,
  input  logic                     wr_y,
  input  logic                     wr_y_only,
  input  logic                     wr_b,
  input  logic                     set_ci,
  output logic [W-1:0]             x_q,
  output logic [W-1:0]             y_q,
  output logic [W-1:0]             b_q,
  output logic                     ci_q,
  output logic [W-1:0]             sum_u,
  output logic [W-1:0]             rd_bus,
  output logic [W-1:0]             wr_bus
);
  oc_adder #(.W(W)) u_add (
    .clk(clk), .rst_n(rst_n), .x(x_q), .y(y_q), .ci(ci_q), .u(sum_u)
  );

  oc_read_bus #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_u(rd_u), .rd_b(rd_b), .rd_bn(rd_bn),
    .u(sum_u), .b(b_q), .bus(rd_bus)
  );

  oc_const_inject #(.W(W)) u_k (
    .clk(clk), .rst_n(rst_n), .rd_bus(rd_bus), .k_sel(k_sel), .wr_bus(wr_bus)
  );

  oc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wbus(wr_bus), .wr_x(wr_x), .wr_y(wr_y),
    .wr_y_only(wr_y_only), .wr_b(wr_b), .set_ci(set_ci),
    .x_q(x_q), .y_q(y_q), .b_q(b_q), .ci_q(ci_q)
  );
endmodule

// File: tb/oc_bus_datapath_test.sv
module oc_bus_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_u = 0, rd_b = 0, rd_bn = 0;
  logic [7:0]  k_sel = '0;
  logic        wr_x = 0, wr_y = 0, wr_y_only = 0, wr_b = 0, set_ci = 0;
  logic [15:0] x_q, y_q, b_q, sum_u, rd_bus, wr_bus;
  logic        ci_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int mx = 0, my = 0, mb = 0, mci = 0;

  always #10 clk = ~clk;

  oc_bus_datapath uut (
    .clk(clk), .rst_n(rst_n), .rd_u(rd_u), .rd_b(rd_b), .rd_bn(rd_bn),
    .k_sel(k_sel), .wr_x(wr_x), .wr_y(wr_y), .wr_y_only(wr_y_only),
    .wr_b(wr_b), .set_ci(set_ci), .x_q(x_q), .y_q(y_q), .b_q(b_q),
    .ci_q(ci_q), .sum_u(sum_u), .rd_bus(rd_bus), .wr_bus(wr_bus)
  );

  function automatic int kconst(input int i);
    case (i)
      0: return 'o020000;
      1: return 'o000001;
      2: return 'o177776;
      3: return 'o000002;
      4: return 'o100000;
      5: return 'o000022;
      6: return 'o000024;
      default: return 'o002000;
    endcase
  endfunction

  function automatic int m_sum();
    int raw = mx + my;
    int c = (((raw >> 16) & 1) != 0 || mci != 0) ? 1 : 0;
    return (raw + c) & 'hFFFF;
  endfunction

  function automatic int m_rd();
    int v = 0;
    if (rd_u)  v |= m_sum();
    if (rd_b)  v |= mb;
    if (rd_bn) v |= (~mb) & 'hFFFF;
    return v;
  endfunction

  function automatic int m_wr();
    int v = m_rd();
    for (int i = 0; i < 8; i++) if (k_sel[i]) v |= kconst(i);
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  task automatic model_clock();
    int wb = m_wr();
    int nx = mx, nci = mci;
    if (wr_x) nx = wb; else if (wr_y) nx = 0;
    if (wr_y || wr_y_only) my = wb;
    if (wr_b) mb = wb;
    if (set_ci) nci = 1; else if (wr_y) nci = 0;
    mx = nx; mci = nci;
  endtask

  // drive at negedge, compare mid-low phase, advance model at posedge
  task automatic step(input bit ru, input bit rb, input bit rbn, input logic [7:0] k,
                      input bit wx, input bit wy, input bit wyo, input bit wbb, input bit sc);
    @(negedge clk);
    rd_u = ru; rd_b = rb; rd_bn = rbn; k_sel = k;
    wr_x = wx; wr_y = wy; wr_y_only = wyo; wr_b = wbb; set_ci = sc;
    #5;
    check("R2 sum", int'(sum_u), m_sum());
    check("R7 rd_bus", int'(rd_bus), m_rd());
    check("R8 wr_bus", int'(wr_bus), m_wr());
    check("R9 x", int'(x_q), mx);
    check("R9 y", int'(y_q), my);
    check("R9 b", int'(b_q), mb);
    check("R9 ci", int'(ci_q), mci);
    @(posedge clk);
    model_clock();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 x", int'(x_q), 0);
    check("R1 y", int'(y_q), 0);
    check("R1 b", int'(b_q), 0);
    check("R1 ci", int'(ci_q), 0);
    @(negedge clk) rst_n = 1'b1;

    // R3: X <= 177777 via constants 177776|000001
    step(0,0,0, 8'b0000_0110, 1,0,0,0,0);
    // R5: Y <= 000001 with wr_y_only; X and ci kept
    step(0,0,0, 8'b0000_0010, 0,0,1,0,0);
    @(negedge clk); #5;
    check("R5 x kept", int'(x_q), 'o177777);
    check("R2 negzero plus one", int'(sum_u), 'o000001);
    // R3: B <= 100000|000024
    step(0,0,0, 8'b0101_0000, 0,0,0,1,0);
    // R7 mask: U | ~B
    step(1,0,1, 8'b0000_0000, 0,0,0,0,0);
    @(negedge clk); #5;
    rd_u = 1; rd_bn = 1;
    #1;
    check("R7 mask", int'(rd_bus), ('o000001 | ((~'o100024) & 'hFFFF)));
    rd_u = 0; rd_bn = 0;
    // R6 then R4: set carry, then wr_y with set_ci keeps it
    step(0,0,0, 8'b0000_0000, 0,0,0,0,1);
    step(0,0,0, 8'b0000_1000, 0,1,0,0,1);
    @(negedge clk); #5;
    check("R4 x cleared", int'(x_q), 0);
    check("R4 ci kept by set_ci", int'(ci_q), 1);
    check("R2 ci adds one", int'(sum_u), 'o000003);
    // R4: wr_y without set_ci clears ci
    step(0,0,0, 8'b1000_0000, 0,1,0,0,0);
    @(negedge clk); #5;
    check("R4 ci cleared", int'(ci_q), 0);
    check("R4 y loaded", int'(y_q), 'o002000);
    // R4: wr_x wins over clear
    step(0,0,0, 8'b0010_0000, 1,1,0,0,0);
    @(negedge clk); #5;
    check("R4 wr_x wins", int'(x_q), 'o000022);
    // R8: all constants, no read
    step(0,0,0, 8'hFF, 0,0,0,0,0);
    // pseudo-random pulses
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[2], lfsr[10:3] & {8{lfsr[11]}},
           lfsr[12], lfsr[13] & lfsr[14], lfsr[15] & ~lfsr[14], lfsr[9] ^ lfsr[4],
           lfsr[5] & lfsr[8]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule